// File: doc/BRIEF.md
# Wrapping DMA Address Generator

This block produces the byte address for one side of a DMA channel, one 32-bit word per transfer. A load strobe captures a start pointer together with a 3-bit wrap code and a side select. The low two bits of the pointer are forced to zero. Each advance strobe then moves the address forward by one word.

When the wrap code is non-zero, the address stays inside a naturally aligned window. The window size is a power of two counted in words. When the word offset inside the window would reach the window size, the address jumps back to the window base. The window base is the loaded pointer with its offset bits cleared. Memory-side and peripheral-side channels use different size lookups for the same code. Code zero gives a plain linear increment.

A DMA channel uses one instance per side. The controller loads each instance when a transfer is programmed and pulses advance once per moved word.

Top module: `wrap_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released with no load, `addr` is 0.
- R2: A `load` at a clock edge makes `addr` equal to `start_ptr` with bits 1:0 cleared after that edge. `addr[1:0]` is always 0.
- R3: When `load` and `advance` are both high at one edge, the load wins and the advance is discarded.
- R4: With a loaded wrap code of 0, each `advance` adds 4 to `addr`. The address rolls over modulo 2^ADDR_W.
- R5: With `side` = 0 (memory) loaded, wrap codes 1 to 7 select windows of 2^(code+4) words, which is 32 to 2048 words. The advance that leaves the last word of the window returns `addr` to the window base.
- R6: With `side` = 1 (peripheral) loaded, wrap codes 1 to 7 select windows of 2^(code-1) words, which is 1 to 64 words. With code 1, `addr` does not move on advance.
- R7: The window base is the loaded pointer with its low log2(window bytes) bits cleared. A pointer loaded mid-window runs to the window end, then wraps to the base, not to the start pointer.
- R8: With neither `load` nor `advance`, `addr` holds its value.
- R9: `wrap_code` and `side` are sampled only on `load`. Changing them between loads has no effect on the address sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| start_ptr | input | ADDR_W | Start byte pointer, captured on load |
| wrap_code | input | 3 | Wrap window code, captured on load |
| side | input | 1 | 0 = memory-side lookup, 1 = peripheral-side lookup; captured on load |
| load | input | 1 | Capture pointer and configuration |
| advance | input | 1 | Step one word |
| addr | output | ADDR_W | Current byte address |

## Verification
The hardest case to reach is the wrap point of the largest memory-side windows. It requires up to 2048 consecutive advances with no intervening load, after a pointer placed at a chosen offset inside the window. Random stimulus with frequent loads almost never gets there. Directed runs therefore load a pointer a few words before the end of a 2048-word window, and also at its base, then advance across the boundary. A long random phase with rare loads mixes both sides and all codes, and a model in the bench predicts every cycle.

// File: rtl/wag_pkg.sv
package wag_pkg;
  typedef enum logic {
    SIDE_MEM    = 1'b0,
    SIDE_PERIPH = 1'b1
  } side_e;

  localparam int unsigned CODE_W = 3;
  localparam int unsigned LG_W   = 4;

  // log2 of the window size in words for a non-zero code
  function automatic logic [LG_W-1:0] window_log2(input side_e s,
                                                  input logic [CODE_W-1:0] c);
    logic [LG_W-1:0] cw;
    cw = {1'b0, c};
    if (s == SIDE_MEM) return cw + 4'd4;
    else               return cw - 4'd1;
  endfunction
endpackage

// File: rtl/wag_reset_sync.sv
module wag_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/wag_window_decode.sv
module wag_window_decode
  import wag_pkg::*;
#(
  parameter int unsigned WORD_W = 30
) (
  input  side_e              side,
  input  logic [CODE_W-1:0]  code,
  output logic               wrap_en,
  output logic [WORD_W-1:0]  mask
);
  logic [LG_W-1:0] lg;

  assign wrap_en = (code != '0);
  assign lg      = window_log2(side, code);

  // one mask bit per word-offset bit: set when inside the window
  for (genvar i = 0; i < WORD_W; i++) begin : g_mask
    assign mask[i] = wrap_en && (int'(lg) > i);
  end
endmodule

// File: rtl/wag_next_word.sv
module wag_next_word #(
  parameter int unsigned WORD_W = 30
) (
  input  logic [WORD_W-1:0] cur,
  input  logic              wrap_en,
  input  logic [WORD_W-1:0] mask,
  output logic [WORD_W-1:0] nxt
);
  logic [WORD_W-1:0] inc;

  always_comb begin
    inc = cur + 1'b1;
    if (wrap_en) nxt = (cur & ~mask) | (inc & mask);
    else         nxt = inc;
  end
endmodule

// File: rtl/wrap_addr_gen.sv
module wrap_addr_gen
  import wag_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] start_ptr,
  input  logic [2:0]        wrap_code,
  input  logic              side,
  input  logic              load,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic              rst_sync_n;
  logic [WORD_W-1:0] word_q, word_d, word_step, load_word;
  logic [2:0]        code_q, code_d;
  side_e             side_q, side_d;
  logic              cfg_en, word_en;
  logic              cfg_wrap_en;
  logic [WORD_W-1:0] cfg_mask;

  wag_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wag_window_decode #(.WORD_W(WORD_W)) u_dec (
    .side    (side_q),
    .code    (code_q),
    .wrap_en (cfg_wrap_en),
    .mask    (cfg_mask)
  );

  wag_next_word #(.WORD_W(WORD_W)) u_step (
    .cur     (word_q),
    .wrap_en (cfg_wrap_en),
    .mask    (cfg_mask),
    .nxt     (word_step)
  );

  assign load_word = WORD_W'(start_ptr >> 2);

  // next-state selection: load has priority over advance
  always_comb begin
    cfg_en  = load;
    word_en = load | advance;
    code_d  = wrap_code;
    side_d  = side_e'(side);
    word_d  = load ? load_word : word_step;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      code_q <= '0;
      side_q <= SIDE_MEM;
    end else if (cfg_en) begin
      code_q <= code_d;
      side_q <= side_d;
    end
  end

  assign addr = {word_q, 2'b00};
endmodule

// File: rtl/wrap_addr_gen_chk.sv
module wrap_addr_gen_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] start_ptr,
  input logic              load,
  input logic              advance,
  input logic [ADDR_W-1:0] addr,
  input logic              cfg_wrap_en,
  input logic [ADDR_W-3:0] cfg_mask
);
  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr[1:0] == 2'b00);

  // R2 R3
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr[ADDR_W-1:2] == $past(start_ptr[ADDR_W-1:2]));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(addr));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && !cfg_wrap_en) |=> addr == $past(addr) + ADDR_W'(4));

  // R7
  window_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && cfg_wrap_en) |=>
      (addr[ADDR_W-1:2] & ~$past(cfg_mask)) ==
      ($past(addr[ADDR_W-1:2]) & ~$past(cfg_mask)));
endmodule

bind wrap_addr_gen wrap_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .start_ptr   (start_ptr),
  .load        (load),
  .advance     (advance),
  .addr        (addr),
  .cfg_wrap_en (cfg_wrap_en),
  .cfg_mask    (cfg_mask)
);

// File: tb/wrap_addr_gen_tb.sv
`timescale 1ns/1ps
module wrap_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] start_ptr;
  logic [2:0]  wrap_code;
  logic        side;
  logic        load, advance;
  logic [31:0] addr;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  logic [31:0] exp_addr;
  logic [2:0]  exp_code;
  logic        exp_side;

  always #2.5 clk = ~clk;

  wrap_addr_gen #(.ADDR_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_ptr(start_ptr), .wrap_code(wrap_code),
    .side(side), .load(load), .advance(advance), .addr(addr)
  );

  function automatic logic [31:0] model_next(logic [31:0] a, logic [2:0] c, logic s);
    int lg;
    logic [31:0] m, w, nw;
    if (c == 3'd0) return a + 32'd4;
    lg = s ? int'(c) - 1 : int'(c) + 4;
    m  = (32'd1 << lg) - 32'd1;
    w  = a >> 2;
    nw = (w & ~m) | ((w + 32'd1) & m);
    return nw << 2;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: addr=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, model updates at posedge, compare at the next negedge
  task automatic step(string req, logic ld, logic adv, logic [31:0] p,
                      logic [2:0] c, logic s);
    load = ld; advance = adv; start_ptr = p; wrap_code = c; side = s;
    @(posedge clk);
    if (ld) begin
      exp_addr = p & ~32'd3; exp_code = c; exp_side = s;
    end else if (adv) begin
      exp_addr = model_next(exp_addr, exp_code, exp_side);
    end
    @(negedge clk);
    check(req, addr, exp_addr);
  endtask

  task automatic advance_n(string req, int n);
    for (int i = 0; i < n; i++) step(req, 1'b0, 1'b1, 32'hDEAD_BEEF, 3'd5, 1'b1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_err++; n_checks++;
      $display("FAIL watchdog: addr=%h expected=finish", addr);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; load = 0; advance = 0; start_ptr = '0; wrap_code = '0; side = 0;
    exp_addr = '0; exp_code = '0; exp_side = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", addr, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", addr, 32'h0);

    // R2: alignment on load; memory code 1 = 32 words
    step("R2", 1, 0, 32'h1000_0003, 3'd1, 1'b0);
    advance_n("R5", 31);
    check("R5", addr, 32'h1000_007C);
    step("R5", 0, 1, 32'h0, 3'd0, 1'b0);
    check("R5", addr, 32'h1000_0000);

    // R5: 2048-word window, loaded near its end
    step("R5", 1, 0, 32'h4000_1FF4, 3'd7, 1'b0);
    advance_n("R5", 3);
    check("R5", addr, 32'h4000_0000);
    advance_n("R5", 2047);
    check("R5", addr, 32'h4000_1FFC);

    // R3: simultaneous load and advance
    step("R3", 1, 1, 32'h0000_1234, 3'd0, 1'b0);
    check("R3", addr, 32'h0000_1234);

    // R4: linear with rollover
    step("R4", 1, 0, 32'hFFFF_FFF8, 3'd0, 1'b1);
    step("R4", 0, 1, 32'h0, 3'd0, 1'b0);
    check("R4", addr, 32'hFFFF_FFFC);
    step("R4", 0, 1, 32'h0, 3'd0, 1'b0);
    check("R4", addr, 32'h0000_0000);

    // R6: peripheral code 1 holds the address
    step("R6", 1, 0, 32'h2000_0010, 3'd1, 1'b1);
    advance_n("R6", 3);
    check("R6", addr, 32'h2000_0010);

    // R7: peripheral 4-word window loaded mid-window wraps to base
    step("R7", 1, 0, 32'h2000_0018, 3'd3, 1'b1);
    step("R7", 0, 1, 32'h0, 3'd0, 1'b0);
    check("R7", addr, 32'h2000_001C);
    step("R7", 0, 1, 32'h0, 3'd0, 1'b0);
    check("R7", addr, 32'h2000_0010);

    // R8: idle hold
    step("R8", 0, 0, 32'hFFFF_FFFF, 3'd7, 1'b1);
    step("R8", 0, 0, 32'h0, 3'd0, 1'b0);
    check("R8", addr, 32'h2000_0010);

    // R9: config changes without load are ignored (advance_n drives code 5, side 1)
    step("R9", 1, 0, 32'h3000_0000, 3'd2, 1'b0);
    advance_n("R9", 64);
    check("R9", addr, 32'h3000_0000);

    // random phase: rare loads, all codes and sides
    for (int i = 0; i < 20000; i++) begin
      logic ld, adv;
      ld  = ($urandom_range(0, 199) == 0);
      adv = ($urandom_range(0, 9) < 8);
      step("R5/R6 random", ld, adv, $urandom, 3'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule